// File: doc/BRIEF.md
# Parallel Filter Bank Output Corrector

This block sits behind a bank of four identical FIR filters that carry three extra check filters. Each check filter is fed the sum of three of the data inputs, so by linearity its output must equal the sum of the matching three data outputs. The block takes all seven filter outputs in one cycle. It forms the three expected check values from the data words and compares each one with the check filter output it belongs to. The result is a 3-bit syndrome that shows which comparisons failed.

From the syndrome the block sees four cases. A clean word passes through unchanged. A pattern that points at one data filter rebuilds that whole word by subtraction from the other outputs. A lone mismatch blames a check filter and leaves the data alone. A rebuild that does not close all three checks is flagged as uncorrectable. All sums and differences wrap at the filter output width. The decision and the output mux are registered, so results appear one clock after the input, together with a registered valid.

Top module: `fbank_ecc_corrector`

## Requirements
- R1: `out_valid` equals the `in_valid` of the previous cycle. When the previous cycle carried no valid input, all three flags and `fix_idx_o` are 0 and the data outputs keep their earlier values.
- R2: While `rst_n` is low, `out_valid`, all flags, `fix_idx_o` and all four data outputs are 0.
- R3: Syndrome bit 0 is set when y1+y2+y3 differs from z1, bit 1 when y1+y2+y4 differs from z2, and bit 2 when y1+y3+y4 differs from z3. With syndrome 000 the data pass through unchanged and all flags and `fix_idx_o` are 0.
- R4: Syndrome 111 rebuilds y1 as z1−y2−y3, with `fixed_o`=1 and `fix_idx_o`=1.
- R5: Syndrome 011 rebuilds y2 as z2−y1−y4, with `fixed_o`=1 and `fix_idx_o`=2.
- R6: Syndrome 101 rebuilds y3 as z3−y1−y4, with `fixed_o`=1 and `fix_idx_o`=3.
- R7: Syndrome 110 rebuilds y4 as z2−y1−y2, with `fixed_o`=1 and `fix_idx_o`=4.
- R8: A syndrome with exactly one bit set raises `chk_fault_o`. The data pass through unchanged and `fix_idx_o` is 0.
- R9: If the rebuilt word set still fails any of the three checks, `uncorr_o` is raised. The data pass through unchanged, `fixed_o`=0 and `fix_idx_o`=0.
- R10: At most one of `fixed_o`, `chk_fault_o` and `uncorr_o` is set in any cycle.
- R11: All sums, comparisons and subtractions are taken modulo 2^W, where W is the output width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word set is valid |
| y1_i | input | W | Data filter 1 output |
| y2_i | input | W | Data filter 2 output |
| y3_i | input | W | Data filter 3 output |
| y4_i | input | W | Data filter 4 output |
| z1_i | input | W | Check filter 1 output (inputs 1,2,3) |
| z2_i | input | W | Check filter 2 output (inputs 1,2,4) |
| z3_i | input | W | Check filter 3 output (inputs 1,3,4) |
| out_valid | output | 1 | Output word set is valid |
| y1_o | output | W | Corrected data word 1 |
| y2_o | output | W | Corrected data word 2 |
| y3_o | output | W | Corrected data word 3 |
| y4_o | output | W | Corrected data word 4 |
| fixed_o | output | 1 | One data word was rebuilt |
| fix_idx_o | output | 3 | Rebuilt filter index, 0 for none, 1..4 |
| chk_fault_o | output | 1 | A single check filter disagrees |
| uncorr_o | output | 1 | Error pattern cannot be corrected |

## Verification
Each output is due exactly one rising edge after the inputs that produced it. Inputs are driven on the falling edge, and outputs are compared on the next falling edge with values the bench computes for the word set it drove one edge earlier. The bench then drives the next set on that same falling edge, so every cycle carries one prediction and one comparison. Cycles with `in_valid` low are checked in the cycle that follows them, which shows that the flags are cleared and the data held.

// File: rtl/fcorr_pkg.sv
package fcorr_pkg;

   localparam int unsigned NDATA = 4;
   localparam int unsigned NCHK  = 3;

   typedef enum logic [1:0] {
      OUTCOME_CLEAN  = 2'd0,
      OUTCOME_FIXED  = 2'd1,
      OUTCOME_CHKBAD = 2'd2,
      OUTCOME_UNCORR = 2'd3
   } fcorr_outcome_e;

   // Data words summed by check k (bit j = data word j)
   function automatic logic [NDATA-1:0] chk_members(input int k);
      case (k)
         0:       return 4'b0111;
         1:       return 4'b1011;
         default: return 4'b1101;
      endcase
   endfunction

   // Syndrome produced by an error on data word i (bit k = check k)
   function automatic logic [NCHK-1:0] data_signature(input int i);
      case (i)
         0:       return 3'b111;
         1:       return 3'b011;
         2:       return 3'b101;
         default: return 3'b110;
      endcase
   endfunction

   // Check used to rebuild data word i
   function automatic int rebuild_src(input int i);
      case (i)
         0:       return 0;
         1:       return 1;
         2:       return 2;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/fcorr_chk_sum.sv
module fcorr_chk_sum
   import fcorr_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic [NDATA-1:0][W-1:0] data,
   input  logic [NCHK-1:0][W-1:0]  chk,
   output logic [NCHK-1:0]         mismatch
);

   for (genvar k = 0; k < NCHK; k++) begin : g_chk
      logic [W-1:0] expect_sum;
      always_comb begin
         expect_sum = '0;
         for (int j = 0; j < NDATA; j++) begin
            if (chk_members(k)[j]) expect_sum = expect_sum + data[j];
         end
         mismatch[k] = (expect_sum != chk[k]);
      end
   end

endmodule

// File: rtl/fcorr_rebuild.sv
module fcorr_rebuild
   import fcorr_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic [NDATA-1:0][W-1:0] data,
   input  logic [NCHK-1:0][W-1:0]  chk,
   output logic [NDATA-1:0][W-1:0] cand
);

   for (genvar i = 0; i < NDATA; i++) begin : g_word
      localparam int SRC = rebuild_src(i);
      always_comb begin
         cand[i] = chk[SRC];
         for (int j = 0; j < NDATA; j++) begin
            if (j != i && chk_members(SRC)[j]) cand[i] = cand[i] - data[j];
         end
      end
   end

endmodule

// File: rtl/fcorr_decode.sv
module fcorr_decode
   import fcorr_pkg::*;
(
   input  logic [NCHK-1:0] syn,
   output logic            clean,
   output logic            chk_only,
   output logic            data_hit,
   output logic [1:0]      data_sel
);

   always_comb begin
      data_hit = 1'b0;
      data_sel = 2'd0;
      for (int i = 0; i < NDATA; i++) begin
         if (syn == data_signature(i)) begin
            data_hit = 1'b1;
            data_sel = 2'(i);
         end
      end
      clean    = (syn == '0);
      chk_only = ($countones(syn) == 1);
   end

endmodule

// File: rtl/fbank_ecc_corrector.sv
module fbank_ecc_corrector
   import fcorr_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] y1_i,
   input  logic [W-1:0] y2_i,
   input  logic [W-1:0] y3_i,
   input  logic [W-1:0] y4_i,
   input  logic [W-1:0] z1_i,
   input  logic [W-1:0] z2_i,
   input  logic [W-1:0] z3_i,
   output logic         out_valid,
   output logic [W-1:0] y1_o,
   output logic [W-1:0] y2_o,
   output logic [W-1:0] y3_o,
   output logic [W-1:0] y4_o,
   output logic         fixed_o,
   output logic [2:0]   fix_idx_o,
   output logic         chk_fault_o,
   output logic         uncorr_o
);

   if (W < 2) begin : g_bad_width
      $error("fbank_ecc_corrector: W must be at least 2");
   end

   logic [NDATA-1:0][W-1:0] data_in, cand, trial;
   logic [NCHK-1:0][W-1:0]  chk_in;
   logic [NCHK-1:0]         syn, post_syn;
   logic                    dec_clean, dec_chk_only, dec_hit;
   logic [1:0]              dec_sel;
   fcorr_outcome_e          outcome;
   logic [NDATA-1:0][W-1:0] data_nxt;
   logic [2:0]              idx_nxt;
   logic [NDATA-1:0][W-1:0] data_q;

   assign data_in = {y4_i, y3_i, y2_i, y1_i};
   assign chk_in  = {z3_i, z2_i, z1_i};

   fcorr_chk_sum #(.W(W)) u_syn (
      .data(data_in), .chk(chk_in), .mismatch(syn)
   );

   fcorr_decode u_dec (
      .syn(syn), .clean(dec_clean), .chk_only(dec_chk_only),
      .data_hit(dec_hit), .data_sel(dec_sel)
   );

   fcorr_rebuild #(.W(W)) u_rebuild (
      .data(data_in), .chk(chk_in), .cand(cand)
   );

   always_comb begin
      trial = data_in;
      trial[dec_sel] = cand[dec_sel];
   end

   fcorr_chk_sum #(.W(W)) u_post (
      .data(trial), .chk(chk_in), .mismatch(post_syn)
   );

   always_comb begin
      data_nxt = data_in;
      idx_nxt  = 3'd0;
      if (dec_clean)                         outcome = OUTCOME_CLEAN;
      else if (dec_chk_only)                 outcome = OUTCOME_CHKBAD;
      else if (dec_hit && post_syn == '0)    outcome = OUTCOME_FIXED;
      else                                   outcome = OUTCOME_UNCORR;
      if (outcome == OUTCOME_FIXED) begin
         data_nxt = trial;
         idx_nxt  = {1'b0, dec_sel} + 3'd1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         fixed_o     <= 1'b0;
         chk_fault_o <= 1'b0;
         uncorr_o    <= 1'b0;
         fix_idx_o   <= 3'd0;
         data_q      <= '0;
      end else begin
         out_valid   <= in_valid;
         fixed_o     <= in_valid && outcome == OUTCOME_FIXED;
         chk_fault_o <= in_valid && outcome == OUTCOME_CHKBAD;
         uncorr_o    <= in_valid && outcome == OUTCOME_UNCORR;
         fix_idx_o   <= in_valid ? idx_nxt : 3'd0;
         if (in_valid) data_q <= data_nxt;
      end
   end

   assign y1_o = data_q[0];
   assign y2_o = data_q[1];
   assign y3_o = data_q[2];
   assign y4_o = data_q[3];

   // R1: valid follows input by one cycle; idle cycles clear flags
   a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !fixed_o && !chk_fault_o && !uncorr_o
                     && fix_idx_o == 3'd0 && $stable(y1_o) && $stable(y4_o)));
   // R4..R7: a reported fix leaves a word set that closes every check
   a_r4_fixed_consistent: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (!fixed_o ||
         (W'(y1_o + y2_o + y3_o) == $past(z1_i) &&
          W'(y1_o + y2_o + y4_o) == $past(z2_i) &&
          W'(y1_o + y3_o + y4_o) == $past(z3_i))));
   a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      fixed_o |-> (fix_idx_o >= 3'd1 && fix_idx_o <= 3'd4));
   // R8/R9: check fault and uncorrectable cases pass the data through
   a_r8_chk_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (!(chk_fault_o || uncorr_o) ||
         (y1_o == $past(y1_i) && y2_o == $past(y2_i) &&
          y3_o == $past(y3_i) && y4_o == $past(y4_i) && fix_idx_o == 3'd0)));
   // R10: flags are mutually exclusive
   a_r10_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fixed_o, chk_fault_o, uncorr_o}));

endmodule

// File: tb/fbank_ecc_corrector_tb_top.sv
module fbank_ecc_corrector_tb_top;

   localparam int unsigned W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] y1_i = '0, y2_i = '0, y3_i = '0, y4_i = '0;
   logic [W-1:0] z1_i = '0, z2_i = '0, z3_i = '0;
   logic         out_valid, fixed_o, chk_fault_o, uncorr_o;
   logic [W-1:0] y1_o, y2_o, y3_o, y4_o;
   logic [2:0]   fix_idx_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   fbank_ecc_corrector #(.W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .y1_i(y1_i), .y2_i(y2_i), .y3_i(y3_i), .y4_i(y4_i),
      .z1_i(z1_i), .z2_i(z2_i), .z3_i(z3_i),
      .out_valid(out_valid), .y1_o(y1_o), .y2_o(y2_o), .y3_o(y3_o), .y4_o(y4_o),
      .fixed_o(fixed_o), .fix_idx_o(fix_idx_o),
      .chk_fault_o(chk_fault_o), .uncorr_o(uncorr_o)
   );

   // expected result of one word set (R3..R11)
   logic [W-1:0] e_y [4];
   logic         e_fix, e_chk, e_unc;
   logic [2:0]   e_idx;
   string        e_tag;

   function automatic logic [2:0] syndrome(input logic [W-1:0] a, b, c, d,
                                           input logic [W-1:0] p, q, r);
      logic [W-1:0] s1, s2, s3;
      s1 = a + b + c; s2 = a + b + d; s3 = a + c + d;
      return {s3 != r, s2 != q, s1 != p};
   endfunction

   task automatic predict(input logic [W-1:0] a, b, c, d, input logic [W-1:0] p, q, r);
      logic [2:0]   s;
      logic [W-1:0] f [4];
      s = syndrome(a, b, c, d, p, q, r);
      e_y[0] = a; e_y[1] = b; e_y[2] = c; e_y[3] = d;
      e_fix = 0; e_chk = 0; e_unc = 0; e_idx = 0;
      f = e_y;
      case (s)
         3'b000: e_tag = "R3";
         3'b001, 3'b010, 3'b100: begin e_chk = 1; e_tag = "R8"; end
         default: begin
            case (s)
               3'b111: begin f[0] = p - b - c; e_idx = 1; e_tag = "R4"; end
               3'b011: begin f[1] = q - a - d; e_idx = 2; e_tag = "R5"; end
               3'b101: begin f[2] = r - a - d; e_idx = 3; e_tag = "R6"; end
               default: begin f[3] = q - a - b; e_idx = 4; e_tag = "R7"; end
            endcase
            if (syndrome(f[0], f[1], f[2], f[3], p, q, r) == 3'b000) begin
               e_fix = 1; e_y = f;
            end else begin
               e_unc = 1; e_idx = 0; e_tag = "R9";
            end
         end
      endcase
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input string act, input string exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %s expected %s", tag, what, act, exp);
      end
   endtask

   // drive at a falling edge, compare at the next falling edge
   task automatic apply(input logic [W-1:0] a, b, c, d, input logic [W-1:0] p, q, r);
      in_valid = 1; y1_i = a; y2_i = b; y3_i = c; y4_i = d;
      z1_i = p; z2_i = q; z3_i = r;
      predict(a, b, c, d, p, q, r);
      @(negedge clk);
      check(out_valid && y1_o == e_y[0] && y2_o == e_y[1] && y3_o == e_y[2] && y4_o == e_y[3],
            e_tag, "data",
            $sformatf("v%0b %h %h %h %h", out_valid, y1_o, y2_o, y3_o, y4_o),
            $sformatf("v1 %h %h %h %h", e_y[0], e_y[1], e_y[2], e_y[3]));
      check({fixed_o, chk_fault_o, uncorr_o, fix_idx_o} == {e_fix, e_chk, e_unc, e_idx}
            && $onehot0({fixed_o, chk_fault_o, uncorr_o}),
            e_tag, "flags R10",
            $sformatf("%b%b%b idx%0d", fixed_o, chk_fault_o, uncorr_o, fix_idx_o),
            $sformatf("%b%b%b idx%0d", e_fix, e_chk, e_unc, e_idx));
   endtask

   task automatic apply_faulty(input logic [W-1:0] a, b, c, d,
                               input logic [W-1:0] ea, eb, ec, ed,
                               input logic [W-1:0] ep, eq, er);
      logic [W-1:0] p, q, r;
      p = a + b + c; q = a + b + d; r = a + c + d;
      apply(a + ea, b + eb, c + ec, d + ed, p + ep, q + eq, r + er);
   endtask

   function automatic logic [W-1:0] nz();
      logic [W-1:0] v;
      v = W'($urandom);
      return (v == '0) ? W'(1) : v;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      logic [W-1:0] hy1, hy2, hy3, hy4;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R2: reset state
      check(!out_valid && !fixed_o && !chk_fault_o && !uncorr_o && fix_idx_o == 0 &&
            y1_o == 0 && y2_o == 0 && y3_o == 0 && y4_o == 0, "R2", "reset",
            $sformatf("v%0b f%b%b%b %h", out_valid, fixed_o, chk_fault_o, uncorr_o, y1_o),
            "all zero");
      rst_n = 1;

      // directed corners, wrap near full scale (R11)
      apply_faulty(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0);
      apply_faulty(16'hFFFF, 16'h8000, 16'h7FFF, 16'h0001, 16'h0005, 0, 0, 0, 0, 0, 0);
      apply_faulty(16'h1234, 16'hFFF0, 16'h0020, 16'h8001, 0, 16'h0100, 0, 0, 0, 0, 0);
      apply_faulty(16'h0001, 16'h0002, 16'hFFFF, 16'h0004, 0, 0, 16'h7777, 0, 0, 0, 0);
      apply_faulty(16'hAAAA, 16'h5555, 16'h0000, 16'hFFFE, 0, 0, 0, 16'h0003, 0, 0, 0);
      apply_faulty(16'h0010, 16'h0020, 16'h0030, 16'h0040, 0, 0, 0, 0, 16'h0001, 0, 0);
      apply_faulty(16'h0010, 16'h0020, 16'h0030, 16'h0040, 0, 0, 0, 0, 0, 16'hFFFF, 0);
      apply_faulty(16'h0010, 16'h0020, 16'h0030, 16'h0040, 0, 0, 0, 0, 0, 0, 16'h8000);
      // R9: two data words wrong
      apply_faulty(16'h0100, 16'h0200, 16'h0300, 16'h0400, 16'h0001, 16'h0002, 0, 0, 0, 0, 0);
      apply_faulty(16'h0100, 16'h0200, 16'h0300, 16'h0400, 0, 0, 16'h0011, 16'h0022, 0, 0, 0);

      // R1: idle cycle holds data and clears flags
      hy1 = y1_o; hy2 = y2_o; hy3 = y3_o; hy4 = y4_o;
      in_valid = 0; y1_i = 16'hDEAD; z1_i = 16'h0BAD;
      @(negedge clk);
      check(!out_valid && !fixed_o && !chk_fault_o && !uncorr_o && fix_idx_o == 0 &&
            y1_o == hy1 && y2_o == hy2 && y3_o == hy3 && y4_o == hy4, "R1", "idle hold",
            $sformatf("v%0b f%b%b%b %h %h", out_valid, fixed_o, chk_fault_o, uncorr_o, y1_o, y4_o),
            $sformatf("v0 f000 %h %h", hy1, hy4));

      // random mix
      for (int n = 0; n < 2000; n++) begin
         logic [W-1:0] a, b, c, d;
         int kind, pos;
         a = W'($urandom); b = W'($urandom); c = W'($urandom); d = W'($urandom);
         kind = $urandom_range(0, 3);
         pos  = $urandom_range(0, 3);
         case (kind)
            0: apply_faulty(a, b, c, d, 0, 0, 0, 0, 0, 0, 0);
            1: apply_faulty(a, b, c, d, pos == 0 ? nz() : 0, pos == 1 ? nz() : 0,
                            pos == 2 ? nz() : 0, pos == 3 ? nz() : 0, 0, 0, 0);
            2: apply_faulty(a, b, c, d, 0, 0, 0, 0, pos == 0 ? nz() : 0,
                            pos == 1 ? nz() : 0, pos >= 2 ? nz() : 0);
            default: apply_faulty(a, b, c, d, nz(), 0, pos[0] ? nz() : 0,
                                  pos[0] ? 0 : nz(), 0, 0, 0);
         endcase
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule